// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's complement operands of width `N` over several clock cycles. A one-cycle `start` pulse, taken only while the block is idle, captures the multiplicand and the multiplier. It then clears the running partial product and the guard bit that sits just below the multiplier's least significant bit. After that the block runs exactly `N` iterations and presents a `2N`-bit signed product.

Each iteration looks at the multiplier register's low bit and the guard bit. The low bit alone sets the arithmetic unit to add (0) or subtract (1). The exclusive-OR of the two bits decides whether that result replaces the partial product. The partial product, the multiplier register and the guard bit are then shifted right together by one place, and the sign bit of the partial product is copied in at the top. Negative multipliers need no correction step.

The partial product register is one bit wider than the operands. Because of this, the most negative multiplicand, and its subtraction in particular, never overflows.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is high and in the cycle after it falls, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` pulse sampled while `busy` is 0 captures `mcand` and `mplier` and raises `busy` on the next clock edge.
- R3: `done` rises exactly N clock edges after the edge that accepted `start`, and it is 0 on every edge in between.
- R4: When `done` is 1, `product` equals the signed two's complement product of the captured operands, sign-extended to 2N bits. This holds for every operand pair, including the most negative value, zero and -1 in either position.
- R5: `done` is high for a single cycle, and `busy` is 0 whenever `done` is 1.
- R6: While `busy` is 1, the `start` input and changes on `mcand` and `mplier` have no effect on the result or on the timing of `done`.
- R7: While `busy` is 0 and no `start` is accepted, `product` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2N | Signed product |

## Verification
On every cycle, the checker confirms the following: the one-cycle done pulse, the exact count of N iterations from acceptance to completion, the hold of the idle product, and the product itself, compared against a signed product of the operands captured at acceptance. Only the bench scenarios can show the rest. These are that operand changes and `start` pulses issued mid-run leave the result and the completion cycle untouched, and that the recoding is right across the whole operand space. The bench shows this by sweeping every operand pair of a five-bit configuration.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } booth_state_e;

    // Per-iteration control derived from the examined bit pair.
    typedef struct packed {
        logic sub_mode;  // 0: add multiplicand, 1: subtract it
        logic commit;    // write arithmetic result into the partial product
    } booth_ctl_t;

    // Mode comes from the low bit alone; commit when the pair differs.
    function automatic booth_ctl_t booth_decode(input logic low_bit, input logic guard_bit);
        booth_ctl_t c;
        c.sub_mode = low_bit;
        c.commit   = low_bit ^ guard_bit;
        return c;
    endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic       low_bit,
    input  logic       guard_bit,
    output booth_ctl_t ctl
);
    always_comb ctl = booth_decode(low_bit, guard_bit);
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
    parameter int W = 9
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         sub_mode,
    output logic [W-1:0] result
);
    logic [W-1:0] rhs_eff;
    logic [W-1:0] cin_vec;

    always_comb begin
        rhs_eff = rhs ^ {W{sub_mode}};
        cin_vec = {{(W-1){1'b0}}, sub_mode};
        result  = lhs + rhs_eff + cin_vec;
    end
endmodule

// File: rtl/booth_step_ctr.sv
module booth_step_ctr #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    output logic last
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

    logic [CW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || load) idx_q <= '0;
        else if (step)   idx_q <= idx_q + 1'b1;
    end

    assign last = (idx_q == LAST_IDX);
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*N-1:0] product
);
    localparam int AW = N + 1;

    booth_state_e state_q;
    logic [AW-1:0] part_q;
    logic [AW-1:0] mcand_q;
    logic [N-1:0]  mplr_q;
    logic          guard_q;
    logic          done_q;

    logic          accept;
    logic          running;
    logic          last_step;
    booth_ctl_t    ctl;
    logic [AW-1:0] arith;
    logic [AW-1:0] part_pick;

    assign running = (state_q == ST_RUN);
    assign accept  = start && !running;

    booth_recode u_recode (
        .low_bit  (mplr_q[0]),
        .guard_bit(guard_q),
        .ctl      (ctl)
    );

    booth_addsub #(.W(AW)) u_addsub (
        .lhs     (part_q),
        .rhs     (mcand_q),
        .sub_mode(ctl.sub_mode),
        .result  (arith)
    );

    booth_step_ctr #(.N(N)) u_ctr (
        .clk (clk),
        .rst (rst),
        .load(accept),
        .step(running),
        .last(last_step)
    );

    assign part_pick = ctl.commit ? arith : part_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            part_q  <= '0;
            mcand_q <= '0;
            mplr_q  <= '0;
            guard_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_RUN;
                part_q  <= '0;
                mcand_q <= {mcand[N-1], mcand};
                mplr_q  <= mplier;
                guard_q <= 1'b0;
            end else if (running) begin
                part_q  <= {part_pick[AW-1], part_pick[AW-1:1]};
                mplr_q  <= {part_pick[0], mplr_q[N-1:1]};
                guard_q <= mplr_q[0];
                if (last_step) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign busy    = running;
    assign done    = done_q;
    assign product = {part_q[N-1:0], mplr_q};
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   mcand,
    input logic [N-1:0]   mplier,
    input logic           busy,
    input logic           done,
    input logic [2*N-1:0] product
);
    localparam int PW = 2 * N;
    localparam int KW = $clog2(N + 1) + 1;

    logic [KW-1:0] edges_q;
    logic [N-1:0]  cap_a_q, cap_b_q;
    logic          rst_d;
    logic signed [PW-1:0] ref_prod;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            edges_q <= '0;
            cap_a_q <= '0;
            cap_b_q <= '0;
        end else if (start && !busy) begin
            edges_q <= '0;
            cap_a_q <= mcand;
            cap_b_q <= mplier;
        end else if (busy) begin
            edges_q <= edges_q + 1'b1;
        end
    end

    always_comb ref_prod = $signed({{N{cap_a_q[N-1]}}, cap_a_q}) * $signed({{N{cap_b_q[N-1]}}, cap_b_q});

    // R1: outputs in reset state in the cycle after reset falls
    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            a_r1_reset_state: assert (!busy && !done && product == '0)
                else $error("R1 reset state violated");
        end
    end

    a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R3 and R6: a mid-run start would restart the count and break this
    a_r3_step_count: assert property (@(posedge clk) disable iff (rst)
        done |-> (edges_q == KW'(N)));

    a_r4_product: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == ref_prod));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mcand  (mcand),
    .mplier (mplier),
    .busy   (busy),
    .done   (done),
    .product(product)
);

// File: tb/booth_seq_mult_bench.sv
`timescale 1ns/1ps
module booth_seq_mult_bench;
    localparam int N    = 5;
    localparam int PW   = 2 * N;
    localparam int FULL = 1 << N;
    localparam int HALF = 1 << (N - 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [N-1:0]   mcand = '0;
    logic [N-1:0]   mplier = '0;
    logic           busy, done;
    logic [PW-1:0]  product;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    booth_seq_mult #(.N(N)) u_booth_seq_mult (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [PW-1:0] expect_prod(input int a, input int b);
        int sa, sb;
        sa = (a >= HALF) ? a - FULL : a;
        sb = (b >= HALF) ? b - FULL : b;
        return PW'(sa * sb);
    endfunction

    // One multiplication; disturb=1 pulses start and changes operands mid-run (R6).
    task automatic run_one(input int a, input int b, input bit disturb);
        logic [PW-1:0] exp_p;
        exp_p  = expect_prod(a, b);
        mcand  = N'(a);
        mplier = N'(b);
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", longint'(busy), 1);
        for (int i = 1; i <= N; i++) begin
            if (disturb && i == 2) begin
                start  = 1'b1;
                mcand  = ~N'(a);
                mplier = N'(b + 3);
            end
            @(negedge clk);
            if (disturb && i == 2) start = 1'b0;
            if (i < N) check(done == 1'b0, "R3", longint'(done), 0);
        end
        check(done == 1'b1, disturb ? "R6" : "R3", longint'(done), 1);
        check(busy == 1'b0, "R5", longint'(busy), 0);
        check(product == exp_p, disturb ? "R6" : "R4", longint'(product), longint'(exp_p));
        @(negedge clk);
        check(done == 1'b0, "R5", longint'(done), 0);
        check(product == exp_p, "R7", longint'(product), longint'(exp_p));
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1", longint'(product), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1", longint'(product), 0);

        // Named corners: most negative, zero, -1, most positive (R4)
        run_one(HALF, HALF, 1'b0);
        run_one(HALF, FULL - 1, 1'b0);
        run_one(FULL - 1, HALF, 1'b0);
        run_one(0, HALF, 1'b0);
        run_one(HALF - 1, HALF, 1'b0);

        // R7: idle with changing operands and no start
        mcand  = '1;
        mplier = '1;
        repeat (4) @(negedge clk);
        begin
            logic [PW-1:0] held;
            held = expect_prod(HALF - 1, HALF);
            check(product == held, "R7", longint'(product), longint'(held));
        end

        // Exhaustive sweep (R4), with mid-run disturbance on a subset (R6)
        for (int a = 0; a < FULL; a++) begin
            for (int b = 0; b < FULL; b++) begin
                run_one(a, b, ((a + b) % 7) == 0);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule